// File: doc/BRIEF.md
# Master Clock Ratio Detector

The block watches a word clock that is synchronous to the master clock. It counts master-clock cycles between successive word-clock rising edges and classifies the count as one of five legal master-to-word ratios: 128, 192, 256, 384 or 512. It has no configuration inputs. The measured ratio alone sets the rate mode, which is high-rate for 128 and 192 and base-rate for the other three. The same ratio sets the two divisors behind the clock-enable strobes that drive downstream datapaths.

The block drives two strobes. The modulator strobe runs at 128 times the sample rate in base-rate mode and at 64 times in high-rate mode. The interpolator strobe runs at four times the sample rate. Each interpolator strobe therefore spans 32 modulator strobes in base-rate mode and 16 in high-rate mode. Both dividers restart on every detected word-clock edge, so the strobes stay aligned to the frame. A count that fits no legal ratio raises an error. Lock needs two consecutive matching measurements and is lost on any mismatch.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is asserted and just after its release, every output is 0.
- R2: A word-clock period that is within ±2 master cycles of 128, 192, 256, 384 or 512 classifies as code 1, 2, 3, 4 or 5 on `ratio_code_o`. Code 0 means unlocked.
- R3: The first rising edge after reset or after a stall only starts the count. Lock rises after two consecutive measurements with the same code. `ratio_code_o` reads 0 while unlocked.
- R4: A measurement of a different legal ratio drops lock without raising an error. The block relocks after two measurements of the new ratio.
- R5: A measurement that matches no legal ratio sets `err_o` and clears lock. The next legal measurement clears `err_o`.
- R6: If no word-clock rising edge arrives for 514 master cycles after the last one, lock drops and `err_o` is set. The block recovers once regular legal edges return.
- R7: `high_rate_o` is 1 only while locked at ratio 128 or 192.
- R8: Over whole word periods, `mod_ce_o` pulses 128 times per period in base-rate mode and 64 times in high-rate mode. It is never high in two adjacent cycles.
- R9: `interp_ce_o` pulses 4 times per word period, and only in cycles where `mod_ce_o` is also high.
- R10: Neither strobe pulses while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_clk_i | input | 1 | Word (frame) clock, synchronous to clk_i |
| ratio_code_o | output | 3 | Locked ratio code (0 none, 1..5 = 128..512) |
| high_rate_o | output | 1 | Locked in high-rate mode |
| lock_o | output | 1 | Ratio confirmed |
| err_o | output | 1 | Last measurement illegal or word clock stalled |
| mod_ce_o | output | 1 | Modulator clock-enable strobe |
| interp_ce_o | output | 1 | Interpolator clock-enable strobe |

## Verification
The bench sweeps all five ratios and checks strobe counts over whole word periods. A divisor taken from the wrong mode would give 2x or 0.5x the expected modulator count. It drives periods exactly at ±2 from a nominal ratio and then one cycle outside that band. An off-by-one in the tolerance window would either hold lock on a bad clock or reject a good one. It checks lock after exactly two and exactly three frames to catch a design that treats the first partial count as a measurement. It also stalls the word clock: a design without a stall timeout would keep stale lock and keep its strobes running.

// File: rtl/mrd_pkg.sv
`timescale 1ns/1ps
package mrd_pkg;
  typedef enum logic [2:0] {
    RC_NONE = 3'd0, RC_128 = 3'd1, RC_192 = 3'd2,
    RC_256  = 3'd3, RC_384 = 3'd4, RC_512 = 3'd5
  } ratio_e;

  localparam int unsigned NUM_RATIOS = 5;
  localparam int unsigned MAX_RATIO  = 512;

  function automatic int unsigned nominal_of(ratio_e c);
    case (c)
      RC_128:  return 128;
      RC_192:  return 192;
      RC_256:  return 256;
      RC_384:  return 384;
      RC_512:  return 512;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_high(ratio_e c);
    return (c == RC_128) || (c == RC_192);
  endfunction

  // master cycles per modulator bit: ratio/64 high-rate, ratio/128 base-rate
  function automatic int unsigned mod_div_of(ratio_e c);
    if (c == RC_NONE) return 2;
    return is_high(c) ? nominal_of(c) / 64 : nominal_of(c) / 128;
  endfunction

  function automatic int unsigned interp_div_of(ratio_e c);
    if (c == RC_NONE) return 4;
    return nominal_of(c) / 4;
  endfunction
endpackage

// File: rtl/mrd_edge_sync.sv
`timescale 1ns/1ps
module mrd_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/mrd_period_meas.sv
`timescale 1ns/1ps
module mrd_period_meas #(
  parameter int unsigned LIMIT = 514,
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] pc_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      seen_q <= 1'b0;
    end else if (rise_i) begin
      pc_q   <= '0;
      seen_q <= 1'b1;
    end else if (pc_q != LIM) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  // first edge only opens the window
  assign meas_valid_o = rise_i & seen_q;
  assign meas_o       = pc_q + 1'b1;
  assign timeout_o    = seen_q & ~rise_i & (pc_q == LIM);
endmodule

// File: rtl/mrd_lock_ctrl.sv
`timescale 1ns/1ps
module mrd_lock_ctrl
  import mrd_pkg::*;
#(
  parameter int unsigned TOL   = 2,
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_valid_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             timeout_i,
  output logic             lock_o,
  output ratio_e           code_o,
  output logic             err_o
);
  ratio_e cls;
  ratio_e prev_q, code_q;
  logic   lock_q, err_q;

  always_comb begin
    int unsigned m;
    int unsigned nom;
    m   = 32'(meas_i);
    cls = RC_NONE;
    for (int k = 1; k <= int'(NUM_RATIOS); k++) begin
      nom = nominal_of(ratio_e'(3'(k)));
      if ((m + TOL >= nom) && (m <= nom + TOL)) cls = ratio_e'(3'(k));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      err_q  <= 1'b0;
      prev_q <= RC_NONE;
      code_q <= RC_NONE;
    end else if (timeout_i) begin
      lock_q <= 1'b0;
      err_q  <= 1'b1;
      prev_q <= RC_NONE;
    end else if (meas_valid_i) begin
      prev_q <= cls;
      err_q  <= (cls == RC_NONE);
      if (cls != RC_NONE && cls == prev_q) begin
        lock_q <= 1'b1;
        code_q <= cls;
      end else begin
        lock_q <= 1'b0;
      end
    end
  end

  assign lock_o = lock_q;
  assign code_o = code_q;
  assign err_o  = err_q;
endmodule

// File: rtl/mrd_strobe_div.sv
`timescale 1ns/1ps
module mrd_strobe_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         ce_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  assign last = (cnt_q == div_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i| last) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign ce_o = en_i & last;
endmodule

// File: rtl/mclk_ratio_detect.sv
`timescale 1ns/1ps
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int unsigned TOL         = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       word_clk_i,
  output logic [2:0] ratio_code_o,
  output logic       high_rate_o,
  output logic       lock_o,
  output logic       err_o,
  output logic       mod_ce_o,
  output logic       interp_ce_o
);
  localparam int unsigned LIMIT = MAX_RATIO + TOL;
  localparam int unsigned CNT_W = $clog2(LIMIT + 2);
  localparam int unsigned DIV_W = $clog2(MAX_RATIO / 4 + 1);
  localparam int unsigned NUM_CE = 2;

  logic             rise;
  logic             meas_valid;
  logic [CNT_W-1:0] meas;
  logic             timeout;
  logic             lock;
  ratio_e           code;
  logic             err;
  logic [DIV_W-1:0] div_val [NUM_CE];
  logic [NUM_CE-1:0] ce;

  mrd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(word_clk_i), .rise_o(rise)
  );

  mrd_period_meas #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
    .meas_valid_o(meas_valid), .meas_o(meas), .timeout_o(timeout)
  );

  mrd_lock_ctrl #(.TOL(TOL), .CNT_W(CNT_W)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .meas_valid_i(meas_valid), .meas_i(meas),
    .timeout_i(timeout), .lock_o(lock), .code_o(code), .err_o(err)
  );

  assign div_val[0] = DIV_W'(mod_div_of(code));
  assign div_val[1] = DIV_W'(interp_div_of(code));

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
    mrd_strobe_div #(.W(DIV_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rise), .en_i(lock),
      .div_i(div_val[g]), .ce_o(ce[g])
    );
  end

  assign ratio_code_o = lock ? code : RC_NONE;
  assign high_rate_o  = lock & is_high(code);
  assign lock_o       = lock;
  assign err_o        = err;
  assign mod_ce_o     = ce[0];
  assign interp_ce_o  = ce[1];
endmodule

// File: rtl/mrd_checker.sv
`timescale 1ns/1ps
module mrd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] ratio_code_o,
  input logic       high_rate_o,
  input logic       lock_o,
  input logic       err_o,
  input logic       mod_ce_o,
  input logic       interp_ce_o
);
  AST_CE_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_ce_o || interp_ce_o) |-> lock_o); // R10

  AST_ERR_NOT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !lock_o); // R5

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |-> $stable(ratio_code_o)); // R4

  AST_INTERP_WITH_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interp_ce_o |-> mod_ce_o); // R9

  AST_MOD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_ce_o |=> !mod_ce_o); // R8

  AST_HIGH_RATE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_rate_o |-> (lock_o && (ratio_code_o == 3'd1 || ratio_code_o == 3'd2))); // R7
endmodule

bind mclk_ratio_detect mrd_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ratio_code_o(ratio_code_o),
  .high_rate_o(high_rate_o), .lock_o(lock_o), .err_o(err_o),
  .mod_ce_o(mod_ce_o), .interp_ce_o(interp_ce_o)
);

// File: tb/mclk_ratio_detect_tb.sv
`timescale 1ns/1ps
module mclk_ratio_detect_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       word_clk_i = 1'b0;
  logic [2:0] ratio_code_o;
  logic       high_rate_o, lock_o, err_o, mod_ce_o, interp_ce_o;

  int n_chk = 0, n_fail = 0;
  int c_mod = 0, c_int = 0, c_orphan = 0, c_adj = 0;
  logic prev_mod = 1'b0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mclk_ratio_detect u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_clk_i(word_clk_i),
    .ratio_code_o(ratio_code_o), .high_rate_o(high_rate_o), .lock_o(lock_o),
    .err_o(err_o), .mod_ce_o(mod_ce_o), .interp_ce_o(interp_ce_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_cycle(logic w);
    @(negedge clk_i);
    if (mod_ce_o) c_mod++;
    if (interp_ce_o) c_int++;
    if (interp_ce_o && !mod_ce_o) c_orphan++;
    if (mod_ce_o && prev_mod) c_adj++;
    prev_mod = mod_ce_o;
    word_clk_i = w;
  endtask

  task automatic send(int r, int n);
    for (int p = 0; p < n; p++)
      for (int i = 0; i < r; i++) drive_cycle(i < r / 2);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive_cycle(1'b0);
  endtask

  task automatic clear_counts();
    c_mod = 0; c_int = 0; c_orphan = 0; c_adj = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check("R1 lock in reset", lock_o, 0);
    check("R1 code in reset", ratio_code_o, 0);
    check("R1 err in reset", err_o, 0);
    rst_ni = 1'b1;
    idle(4);
    check("R1 strobes after reset", mod_ce_o | interp_ce_o | high_rate_o, 0);
    check("R1 lock after reset", lock_o | err_o, 0);
  endtask

  task automatic t_first_lock();
    send(256, 2);
    check("R3 no lock after one measurement", lock_o, 0);
    check("R3 code zero unlocked", ratio_code_o, 0);
    send(256, 1);
    check("R3 lock after two measurements", lock_o, 1);
    check("R2 code for 256", ratio_code_o, 3);
  endtask

  task automatic t_sweep();
    int rl [5] = '{384, 512, 192, 128, 256};
    int cl [5] = '{4, 5, 2, 1, 3};
    for (int k = 0; k < 5; k++) begin
      automatic bit hr = (rl[k] < 256);
      send(rl[k], 2);
      check("R4 lock dropped on new ratio", lock_o, 0);
      check("R4 no error on legal change", err_o, 0);
      send(rl[k], 2);
      check("R4 relock", lock_o, 1);
      check("R2 ratio code", ratio_code_o, cl[k]);
      check("R7 high rate flag", high_rate_o, int'(hr));
      clear_counts();
      send(rl[k], 2);
      check("R8 modulator strobe count", c_mod, hr ? 128 : 256);
      check("R8 no adjacent strobes", c_adj, 0);
      check("R9 interpolator strobe count", c_int, 8);
      check("R9 interp aligned to mod", c_orphan, 0);
    end
  endtask

  task automatic t_tolerance();
    send(130, 2);
    check("R4 drop from 256 to 130", lock_o, 0);
    send(130, 2);
    check("R2 lock at +2", lock_o, 1);
    check("R2 code at +2", ratio_code_o, 1);
    send(126, 3);
    check("R2 lock held at -2", lock_o, 1);
    check("R2 code at -2", ratio_code_o, 1);
    check("R2 no error at -2", err_o, 0);
    send(131, 2);
    check("R5 error at +3", err_o, 1);
    check("R5 lock cleared", lock_o, 0);
    check("R5 code zero", ratio_code_o, 0);
    send(300, 2);
    check("R5 error between ratios", err_o, 1);
    send(384, 2);
    check("R5 error cleared by legal", err_o, 0);
    check("R5 not yet locked", lock_o, 0);
    send(384, 2);
    check("R5 relock after error", lock_o, 1);
    check("R2 code 384", ratio_code_o, 4);
  endtask

  task automatic t_timeout();
    idle(600);
    check("R6 lock lost on stall", lock_o, 0);
    check("R6 error on stall", err_o, 1);
    check("R6 code zero on stall", ratio_code_o, 0);
    clear_counts();
    idle(100);
    check("R10 no mod strobes unlocked", c_mod, 0);
    check("R10 no interp strobes unlocked", c_int, 0);
    send(512, 4);
    check("R6 recover lock", lock_o, 1);
    check("R6 recover code", ratio_code_o, 5);
    check("R6 error cleared", err_o, 0);
    check("R7 base rate flag", high_rate_o, 0);
  endtask

  initial begin
    t_reset();
    t_first_lock();
    t_sweep();
    t_tolerance();
    t_timeout();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule